// File: doc/BRIEF.md
# Branch Direction and Target Predictor with Static Fallback

This block sits in an instruction front end and predicts, for a fetched branch, whether it will be taken and where it will go. A lookup is keyed on the linear address of the instruction, so a table hit gives a prediction that does not depend on decoding the branch. The table is direct-mapped and tagged. Each entry keeps a valid bit, an address tag, a target address and a 2-bit saturating direction counter.

When the table has no matching entry, the block does not default to not-taken. It uses the branch displacement, instruction length and any direction hint prefix that decode supplies with the request. A hint decides the direction when one is present. Without a hint, the sign of the displacement decides it: backward branches are predicted taken and forward branches not taken. A table hit always wins over a hint.

Retired branches write their resolved outcome and target through a separate update port. A miss on that port allocates the entry. A hit trains the entry's counter. The output marks which of the three sources produced each prediction.

Top module: `brpred_top`

## Requirements
- R1: A lookup request (`lk_valid` high) produces `pred_valid` high exactly two clock cycles later, and `pred_valid` is low in every other cycle. After reset `pred_valid` is low and every table entry is invalid, so every lookup misses.
- R2: On a hit (the entry at index `addr[INDEX_W-1:0]` is valid and its tag equals `addr[ADDR_W-1:INDEX_W]`), `pred_src` is 2 and `pred_target` is the stored target. `pred_taken` is bit 1 of the stored counter. The hint and the displacement have no effect.
- R3: On a miss with no hint (`lk_hint` 00 or 11) and a negative displacement, the prediction is taken. `pred_src` is 0, and `pred_target` is `lk_addr + lk_len + sign-extended lk_disp`.
- R4: On a miss with no hint and a non-negative displacement (zero included), the prediction is not taken. `pred_src` is 0, and `pred_target` is the fall-through address `lk_addr + lk_len`.
- R5: On a miss, `lk_hint` 10 predicts taken with the computed target. `lk_hint` 01 predicts not taken with the fall-through address, even for a backward branch. In both cases `pred_src` is 1.
- R6: An update that misses allocates the entry: valid, the update tag, the update target, and a counter of 2 if taken or 1 if not taken.
- R7: An update that hits moves the counter up on taken and down on not-taken, saturating at 3 and at 0, and overwrites the stored target.
- R8: An update to an index holding a different tag replaces that entry, so the address that held it before then misses.
- R9: When a lookup and an update use the same index in the same cycle, the lookup returns the contents from before the update. A later lookup sees the updated entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | ADDR_W | Linear address of the branch |
| lk_disp | input | DISP_W | Signed branch displacement from decode |
| lk_len | input | LEN_W | Instruction length in bytes |
| lk_hint | input | 2 | Direction hint: 00 none, 01 not taken, 10 taken, 11 none |
| up_valid | input | 1 | Retirement update request |
| up_addr | input | ADDR_W | Address of the retired branch |
| up_taken | input | 1 | Resolved direction |
| up_target | input | ADDR_W | Resolved target address |
| pred_valid | output | 1 | Prediction valid |
| pred_taken | output | 1 | Predicted direction |
| pred_target | output | ADDR_W | Predicted next address |
| pred_src | output | 2 | Source: 0 static rule, 1 hint, 2 table |

## Verification
The bench builds the block with ADDR_W=16, INDEX_W=2, DISP_W=8 and LEN_W=4. With only four entries, addresses four apart share an index, so tag mismatch and replacement after aliasing are reached with a handful of updates. The 8-bit displacement makes backward branches easy to write as literal bytes. One address is walked through a long run of taken and not-taken updates to reach both counter limits. The same index is also looked up and updated in one cycle.

// File: rtl/brpred_pkg.sv
package brpred_pkg;

  typedef enum logic [1:0] {
    SRC_STATIC = 2'd0,
    SRC_HINT   = 2'd1,
    SRC_BTB    = 2'd2
  } pred_src_e;

  localparam logic [1:0] HINT_NT = 2'b01;
  localparam logic [1:0] HINT_T  = 2'b10;

  // Saturating step of a 2-bit direction counter
  function automatic logic [1:0] ctr_step(input logic [1:0] c, input logic taken);
    if (taken) return (c == 2'b11) ? 2'b11 : c + 2'b01;
    else       return (c == 2'b00) ? 2'b00 : c - 2'b01;
  endfunction

  // Weak state matching the first resolved outcome
  function automatic logic [1:0] ctr_first(input logic taken);
    return taken ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/brpred_fallback.sv
module brpred_fallback #(
  parameter int ADDR_W = 32,
  parameter int DISP_W = 16,
  parameter int LEN_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [DISP_W-1:0] disp,
  input  logic [LEN_W-1:0]  len,
  input  logic [1:0]        hint,
  output logic              taken,
  output logic              hinted,
  output logic [ADDR_W-1:0] target
);
  import brpred_pkg::*;

  localparam int DEXT = ADDR_W - DISP_W;
  localparam int LEXT = ADDR_W - LEN_W;

  logic [ADDR_W-1:0] fall_through;
  logic [ADDR_W-1:0] disp_ext;

  always_comb begin
    fall_through = addr + {{LEXT{1'b0}}, len};
    disp_ext     = {{DEXT{disp[DISP_W-1]}}, disp};
    hinted       = (hint == HINT_T) || (hint == HINT_NT);
    if (hint == HINT_T)       taken = 1'b1;
    else if (hint == HINT_NT) taken = 1'b0;
    else                      taken = disp[DISP_W-1];
    target = taken ? (fall_through + disp_ext) : fall_through;
  end

endmodule

// File: rtl/brpred_table.sv
module brpred_table #(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_hit,
  output logic              rd_taken,
  output logic [ADDR_W-1:0] rd_target,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target
);
  import brpred_pkg::*;

  localparam int TAG_W = ADDR_W - INDEX_W;
  localparam int DEPTH = 1 << INDEX_W;

  logic [DEPTH-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_mem [DEPTH];
  logic [ADDR_W-1:0] tgt_mem [DEPTH];
  logic [1:0]        ctr_mem [DEPTH];

  logic [INDEX_W-1:0] rd_idx, up_idx;
  logic [TAG_W-1:0]   rd_tag, up_tag;
  assign rd_idx = rd_addr[INDEX_W-1:0];
  assign rd_tag = rd_addr[ADDR_W-1:INDEX_W];
  assign up_idx = up_addr[INDEX_W-1:0];
  assign up_tag = up_addr[ADDR_W-1:INDEX_W];

  // Read port: registered, returns contents from before a same-cycle write
  logic              rd_vbit_q;
  logic [TAG_W-1:0]  rd_tag_q, rd_stored_tag_q;
  logic [ADDR_W-1:0] rd_tgt_q;
  logic [1:0]        rd_ctr_q;

  always_ff @(posedge clk) begin
    if (rd_en) begin
      rd_tag_q        <= rd_tag;
      rd_stored_tag_q <= tag_mem[rd_idx];
      rd_tgt_q        <= tgt_mem[rd_idx];
      rd_ctr_q        <= ctr_mem[rd_idx];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_vbit_q <= 1'b0;
    else if (rd_en) rd_vbit_q <= valid_q[rd_idx];
  end

  assign rd_hit    = rd_vbit_q && (rd_stored_tag_q == rd_tag_q);
  assign rd_taken  = rd_ctr_q[1];
  assign rd_target = rd_tgt_q;

  // Update port: allocate on miss, train on hit
  logic       up_hit;
  logic [1:0] up_ctr_new;

  always_comb begin
    up_hit     = valid_q[up_idx] && (tag_mem[up_idx] == up_tag);
    up_ctr_new = up_hit ? ctr_step(ctr_mem[up_idx], up_taken) : ctr_first(up_taken);
  end

  always_ff @(posedge clk) begin
    if (up_valid) begin
      tag_mem[up_idx] <= up_tag;
      tgt_mem[up_idx] <= up_target;
      ctr_mem[up_idx] <= up_ctr_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           valid_q <= '0;
    else if (up_valid) valid_q[up_idx] <= 1'b1;
  end

  AST_ALLOC_WEAK: assert property (@(posedge clk) disable iff (rst)
    (up_valid && !up_hit) |=> (valid_q[$past(up_idx)] &&
      ctr_mem[$past(up_idx)] == ($past(up_taken) ? 2'b10 : 2'b01))); // R6

  AST_CTR_CEIL: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_hit && up_taken && ctr_mem[up_idx] == 2'b11)
      |=> (ctr_mem[$past(up_idx)] == 2'b11)); // R7

  AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (rst)
    (up_valid && up_hit && !up_taken && ctr_mem[up_idx] == 2'b00)
      |=> (ctr_mem[$past(up_idx)] == 2'b00)); // R7

  AST_TARGET_WRITE: assert property (@(posedge clk) disable iff (rst)
    up_valid |=> (tgt_mem[$past(up_idx)] == $past(up_target))); // R7

endmodule

// File: rtl/brpred_top.sv
module brpred_top #(
  parameter int ADDR_W  = 32,
  parameter int INDEX_W = 6,
  parameter int DISP_W  = 16,
  parameter int LEN_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              lk_valid,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic [DISP_W-1:0] lk_disp,
  input  logic [LEN_W-1:0]  lk_len,
  input  logic [1:0]        lk_hint,
  input  logic              up_valid,
  input  logic [ADDR_W-1:0] up_addr,
  input  logic              up_taken,
  input  logic [ADDR_W-1:0] up_target,
  output logic              pred_valid,
  output logic              pred_taken,
  output logic [ADDR_W-1:0] pred_target,
  output logic [1:0]        pred_src
);
  import brpred_pkg::*;

  // Stage 0: fallback decision in parallel with the table read
  logic              fb_taken, fb_hinted;
  logic [ADDR_W-1:0] fb_target;

  brpred_fallback #(.ADDR_W(ADDR_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) u_fallback (
    .addr   (lk_addr),
    .disp   (lk_disp),
    .len    (lk_len),
    .hint   (lk_hint),
    .taken  (fb_taken),
    .hinted (fb_hinted),
    .target (fb_target)
  );

  logic              tbl_hit, tbl_taken;
  logic [ADDR_W-1:0] tbl_target;

  brpred_table #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (lk_valid),
    .rd_addr   (lk_addr),
    .rd_hit    (tbl_hit),
    .rd_taken  (tbl_taken),
    .rd_target (tbl_target),
    .up_valid  (up_valid),
    .up_addr   (up_addr),
    .up_taken  (up_taken),
    .up_target (up_target)
  );

  // Stage 1: hold the fallback result beside the table data
  logic              s1_valid, s1_taken, s1_hinted;
  logic [ADDR_W-1:0] s1_target;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_taken  <= 1'b0;
      s1_hinted <= 1'b0;
      s1_target <= '0;
    end else begin
      s1_valid <= lk_valid;
      if (lk_valid) begin
        s1_taken  <= fb_taken;
        s1_hinted <= fb_hinted;
        s1_target <= fb_target;
      end
    end
  end

  // Stage 2: priority select into registered outputs (table > hint > static)
  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid  <= 1'b0;
      pred_taken  <= 1'b0;
      pred_target <= '0;
      pred_src    <= SRC_STATIC;
    end else begin
      pred_valid <= s1_valid;
      if (s1_valid) begin
        if (tbl_hit) begin
          pred_taken  <= tbl_taken;
          pred_target <= tbl_target;
          pred_src    <= SRC_BTB;
        end else begin
          pred_taken  <= s1_taken;
          pred_target <= s1_target;
          pred_src    <= s1_hinted ? SRC_HINT : SRC_STATIC;
        end
      end
    end
  end

  AST_PRED_LATENCY: assert property (@(posedge clk) disable iff (rst)
    lk_valid |=> ##1 pred_valid); // R1

  AST_PRED_IDLE: assert property (@(posedge clk) disable iff (rst)
    !lk_valid |=> ##1 !pred_valid); // R1

  AST_HINT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && pred_src == SRC_HINT) |->
      ($past(lk_hint, 2) == HINT_T || $past(lk_hint, 2) == HINT_NT)); // R5

  AST_SRC_CODE: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> (pred_src != 2'b11)); // R2

endmodule

// File: tb/tb_brpred_top.sv
module tb_brpred_top;
  localparam int ADDR_W  = 16;
  localparam int INDEX_W = 2;
  localparam int DISP_W  = 8;
  localparam int LEN_W   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              lk_valid = 1'b0;
  logic [ADDR_W-1:0] lk_addr = '0;
  logic [DISP_W-1:0] lk_disp = '0;
  logic [LEN_W-1:0]  lk_len = '0;
  logic [1:0]        lk_hint = '0;
  logic              up_valid = 1'b0;
  logic [ADDR_W-1:0] up_addr = '0;
  logic              up_taken = 1'b0;
  logic [ADDR_W-1:0] up_target = '0;
  logic              pred_valid, pred_taken;
  logic [ADDR_W-1:0] pred_target;
  logic [1:0]        pred_src;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  brpred_top #(.ADDR_W(ADDR_W), .INDEX_W(INDEX_W), .DISP_W(DISP_W), .LEN_W(LEN_W)) dut (
    .clk(clk), .rst(rst),
    .lk_valid(lk_valid), .lk_addr(lk_addr), .lk_disp(lk_disp), .lk_len(lk_len), .lk_hint(lk_hint),
    .up_valid(up_valid), .up_addr(up_addr), .up_taken(up_taken), .up_target(up_target),
    .pred_valid(pred_valid), .pred_taken(pred_taken), .pred_target(pred_target), .pred_src(pred_src)
  );

  task automatic expect_pred(string req, bit ev, bit et, logic [ADDR_W-1:0] eg, logic [1:0] es);
    checks++;
    if (pred_valid !== ev || (ev && (pred_taken !== et || pred_target !== eg || pred_src !== es))) begin
      errors++;
      $display("FAIL %s: valid=%0b taken=%0b target=%h src=%0d expected valid=%0b taken=%0b target=%h src=%0d",
               req, pred_valid, pred_taken, pred_target, pred_src, ev, et, eg, es);
    end
  endtask

  // Drive one lookup; return at the negedge where its prediction is visible
  task automatic lookup(logic [ADDR_W-1:0] a, logic [DISP_W-1:0] d, logic [LEN_W-1:0] l, logic [1:0] h);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = a; lk_disp = d; lk_len = l; lk_hint = h;
    @(negedge clk);
    lk_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic update(logic [ADDR_W-1:0] a, bit t, logic [ADDR_W-1:0] g);
    @(negedge clk);
    up_valid = 1'b1; up_addr = a; up_taken = t; up_target = g;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset_static;
    expect_pred("R1 reset", 1'b0, 1'b0, '0, 2'd0);
    lookup(16'h1000, 8'hFC, 4'd2, 2'b00);
    expect_pred("R3 backward static", 1'b1, 1'b1, 16'h0FFE, 2'd0);
    @(negedge clk);
    expect_pred("R1 idle after prediction", 1'b0, 1'b0, '0, 2'd0);
    lookup(16'h1001, 8'h10, 4'd3, 2'b00);
    expect_pred("R4 forward static", 1'b1, 1'b0, 16'h1004, 2'd0);
    lookup(16'h1100, 8'h00, 4'd1, 2'b00);
    expect_pred("R4 zero displacement", 1'b1, 1'b0, 16'h1101, 2'd0);
    lookup(16'h1200, 8'hF0, 4'd2, 2'b11);
    expect_pred("R3 hint code 11 as none", 1'b1, 1'b1, 16'h11F2, 2'd0);
  endtask

  task automatic t_hints;
    lookup(16'h2002, 8'h20, 4'd2, 2'b10);
    expect_pred("R5 hint taken on forward", 1'b1, 1'b1, 16'h2024, 2'd1);
    lookup(16'h2100, 8'hFC, 4'd2, 2'b01);
    expect_pred("R5 hint not-taken on backward", 1'b1, 1'b0, 16'h2102, 2'd1);
  endtask

  task automatic t_alloc;
    update(16'h3000, 1'b1, 16'h3456);
    lookup(16'h3000, 8'hFC, 4'd2, 2'b01);
    expect_pred("R6 R2 taken allocation beats hint", 1'b1, 1'b1, 16'h3456, 2'd2);
    update(16'h3001, 1'b0, 16'h3999);
    lookup(16'h3001, 8'hFC, 4'd2, 2'b10);
    expect_pred("R6 R2 not-taken allocation", 1'b1, 1'b0, 16'h3999, 2'd2);
  endtask

  task automatic t_counter;
    update(16'h3000, 1'b0, 16'h3456);
    lookup(16'h3000, 8'h10, 4'd2, 2'b00);
    expect_pred("R7 decrement 2 to 1", 1'b1, 1'b0, 16'h3456, 2'd2);
    update(16'h3000, 1'b0, 16'h3456);
    update(16'h3000, 1'b0, 16'h3456);
    update(16'h3000, 1'b1, 16'h3456);
    lookup(16'h3000, 8'h10, 4'd2, 2'b00);
    expect_pred("R7 floor holds at 0", 1'b1, 1'b0, 16'h3456, 2'd2);
    update(16'h3000, 1'b1, 16'h3456);
    lookup(16'h3000, 8'h10, 4'd2, 2'b00);
    expect_pred("R7 increment 1 to 2", 1'b1, 1'b1, 16'h3456, 2'd2);
    update(16'h3000, 1'b1, 16'h3456);
    update(16'h3000, 1'b1, 16'h3500);
    update(16'h3000, 1'b0, 16'h3500);
    lookup(16'h3000, 8'h10, 4'd2, 2'b00);
    expect_pred("R7 ceiling holds at 3 and target rewritten", 1'b1, 1'b1, 16'h3500, 2'd2);
    update(16'h3000, 1'b0, 16'h3500);
    lookup(16'h3000, 8'h10, 4'd2, 2'b00);
    expect_pred("R7 decrement 2 to 1 again", 1'b1, 1'b0, 16'h3500, 2'd2);
  endtask

  task automatic t_alias;
    lookup(16'h3004, 8'h10, 4'd2, 2'b00);
    expect_pred("R8 tag mismatch misses", 1'b1, 1'b0, 16'h3006, 2'd0);
    update(16'h3004, 1'b1, 16'h4444);
    lookup(16'h3004, 8'h10, 4'd2, 2'b00);
    expect_pred("R8 replacing entry hits", 1'b1, 1'b1, 16'h4444, 2'd2);
    lookup(16'h3000, 8'h10, 4'd2, 2'b00);
    expect_pred("R8 evicted address misses", 1'b1, 1'b0, 16'h3002, 2'd0);
  endtask

  task automatic t_same_cycle;
    update(16'h5002, 1'b1, 16'h5100);
    @(negedge clk);
    lk_valid = 1'b1; lk_addr = 16'h5002; lk_disp = 8'h10; lk_len = 4'd2; lk_hint = 2'b00;
    up_valid = 1'b1; up_addr = 16'h5002; up_taken = 1'b0; up_target = 16'h5200;
    @(negedge clk);
    lk_valid = 1'b0; up_valid = 1'b0;
    @(negedge clk);
    expect_pred("R9 same-cycle lookup sees old entry", 1'b1, 1'b1, 16'h5100, 2'd2);
    lookup(16'h5002, 8'h10, 4'd2, 2'b00);
    expect_pred("R9 later lookup sees update", 1'b1, 1'b0, 16'h5200, 2'd2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_static();
    t_hints();
    t_alloc();
    t_counter();
    t_alias();
    t_same_cycle();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule